// File: doc/BRIEF.md
# MSI message capture controller

This block sits on the inbound write path of a PCIe root port, after transaction decoding. Every inbound memory write is compared with a programmed target address and a masked data pattern. A write that hits is consumed: the low, unmasked bits of its data are taken as a vector number, and the status bit for that vector is latched. All other writes go on downstream, one cycle later and unchanged. A single level interrupt line tells the CPU that at least one unmasked vector is pending.

Software uses a flat eight-entry register port to do four things: program the target address and the enable bit, set the data mask and pattern pair, read the status word and set bits in it or clear them, and mask vectors or unmask them. The number of free low bits in the data mask sets the number of vectors, from 1 to 32. The vectors fill the top end of the 32-bit status word. With 32 vectors they cover bits 0 to 31. With 8 vectors they cover bits 24 to 31.

Top module: `msi_capture_ctrl`

## Requirements
- R1: After reset the following all read zero: status, enable, target address and data configuration. Every mask bit reads one. `irq` and `out_valid` are low.
- R2: Register port, with writes taking effect at the clock edge and `reg_rdata` combinational from `reg_addr`. The entries are:
  - 0: address low word. Bit 0 is the enable and bits 31:2 are target address bits 31:2. It reads back as {addr[31:2], 0, enable}.
  - 1: address high word. Its low bits hold target address bits ADDR_W-1:32 and it reads zero-extended.
  - 2: data configuration, with the mask in bits 31:16 and the pattern in bits 15:0.
  - 3: status, read-only.
  - 4: clear. Write ones to clear; it reads status.
  - 5: set. Write ones to set; it reads status.
  - 6: mask set. Write ones to mask; it reads the mask.
  - 7: mask clear. Write ones to unmask; it reads the mask.
- R3: An inbound write hits only when all three hold: enable is 1, its address equals {high word, low word bits 31:2, 2'b00}, and (data[15:0] AND mask) equals (pattern AND mask). Data bits 31:16 play no part.
- R4: On a hit, k is the count of trailing zero bits in the mask, capped at 5. The status bit set at the next edge is data[k-1:0] + 32 - 2^k. So mask 0xFFE0 maps vector v to bit v, and mask 0xFFF8 maps vector v to bit v+24.
- R5: A write that does not hit, including a matching write while enable is 0, appears on `out_valid`/`out_addr`/`out_data` one cycle later, unchanged. It leaves status alone. A write that hits is never forwarded.
- R6: Writing to the clear entry clears the status bits written as one, and writing to the set entry sets them. Writes to the status entry have no effect.
- R7: When a bit is set (by a hit or by the set entry) and cleared in the same cycle, the bit ends up set.
- R8: The mask-set and mask-clear entries change only the mask. A masked vector still latches its status bit.
- R9: `irq` is high exactly when some status bit is set, unmasked, and implemented. A bit is implemented when its index is at least 32 - 2^k.
- R10: A status bit cleared by software sets again on a later hit for the same vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Inbound memory write present |
| in_addr | input | ADDR_W | Inbound write address |
| in_data | input | 32 | Inbound write data |
| out_valid | output | 1 | Forwarded write present |
| out_addr | output | ADDR_W | Forwarded write address |
| out_data | output | 32 | Forwarded write data |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq | output | 1 | Level interrupt toward the CPU |

## Verification
The assertions take for granted that inputs are stable around the clock edge. They also assume that `in_addr` and `in_data` are meaningful only while `in_valid` is high, so the forwarding checks look at data only in cycles that carry a write. The stimulus drives every input on the falling edge. Random inbound writes mostly aim at the programmed target, with data that fits the current pattern, so hits are frequent. Register writes to the clear and set entries are sometimes placed in the same cycle as a hit, which exercises the set-versus-clear rule.

// File: rtl/msi_cap_pkg.sv
// Package: shared constants, register index encoding and the helper that
// derives the number of free vector bits from the data mask.
package msi_cap_pkg;
    localparam int MSG_W        = 32;              // inbound data width
    localparam int STAT_W       = 32;              // status/mask word width
    localparam int HALF_W       = MSG_W / 2;       // mask and pattern width
    localparam int VEC_LOG2     = $clog2(STAT_W);  // widest vector field
    localparam int REG_AW       = 3;               // register index width

    typedef enum logic [REG_AW-1:0] {
        RA_ADDR_LO  = 3'd0,
        RA_ADDR_HI  = 3'd1,
        RA_DATA_CFG = 3'd2,
        RA_STATUS   = 3'd3,
        RA_CLEAR    = 3'd4,
        RA_SET      = 3'd5,
        RA_MASK_SET = 3'd6,
        RA_MASK_CLR = 3'd7
    } reg_addr_e;

    // Count trailing zeros of the mask, capped at VEC_LOG2.
    function automatic logic [VEC_LOG2:0] free_bits(input logic [HALF_W-1:0] m);
        logic [VEC_LOG2:0] k;
        k = (VEC_LOG2+1)'(VEC_LOG2);
        for (int i = VEC_LOG2 - 1; i >= 0; i--) begin
            if (m[i]) k = (VEC_LOG2+1)'(i);
        end
        return k;
    endfunction
endpackage

// File: rtl/msi_match.sv
// Module: msi_match
// Decides whether the current inbound write is an interrupt message and,
// if so, which status bit it targets. Also reports which status bits are
// implemented under the current mask. Purely combinational.
// Assumes: target address bits [1:0] are held at zero by the register block.
module msi_match
    import msi_cap_pkg::*;
#(
    parameter int ADDR_W = 36
) (
    input  logic                in_valid,
    input  logic [ADDR_W-1:0]   in_addr,
    input  logic [MSG_W-1:0]    in_data,
    input  logic                en,
    input  logic [ADDR_W-1:0]   tgt_addr,
    input  logic [HALF_W-1:0]   cfg_mask,
    input  logic [HALF_W-1:0]   cfg_pat,
    output logic                hit,
    output logic [VEC_LOG2-1:0] cap_idx,
    output logic [STAT_W-1:0]   impl
);
    logic [VEC_LOG2:0] k;
    int span;
    int low;
    logic addr_eq;
    logic data_eq;

    // Vector decode: free bits select a vector placed at the top of status.
    always_comb begin
        k    = free_bits(cfg_mask);
        span = 1 << int'(k);
        low  = int'(in_data[VEC_LOG2-1:0]) & (span - 1);
        cap_idx = VEC_LOG2'(low + STAT_W - span);
        for (int i = 0; i < STAT_W; i++) begin
            impl[i] = (i >= STAT_W - span);
        end
    end

    // Address and masked data comparison.
    always_comb begin
        addr_eq = (in_addr == tgt_addr);
        data_eq = (((in_data[HALF_W-1:0] ^ cfg_pat) & cfg_mask) == '0);
        hit     = in_valid && en && addr_eq && data_eq;
    end
endmodule

// File: rtl/msi_regs.sv
// Module: msi_regs
// Holds the enable, target address and data configuration, decodes register
// writes into set/clear strobes for the status and mask words, and drives
// the read data multiplexer.
// Assumes: ADDR_W is greater than 32 and at most 64.
module msi_regs
    import msi_cap_pkg::*;
#(
    parameter int ADDR_W = 36
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [MSG_W-1:0]    reg_wdata,
    input  logic [STAT_W-1:0]   status,
    input  logic [STAT_W-1:0]   mask,
    output logic                en,
    output logic [ADDR_W-1:0]   tgt_addr,
    output logic [HALF_W-1:0]   cfg_mask,
    output logic [HALF_W-1:0]   cfg_pat,
    output logic [STAT_W-1:0]   sw_clr,
    output logic [STAT_W-1:0]   sw_set,
    output logic [STAT_W-1:0]   msk_set,
    output logic [STAT_W-1:0]   msk_clr,
    output logic [MSG_W-1:0]    reg_rdata
);
    localparam int HI_W = ADDR_W - 32;

    logic [31:2]     addr_lo_q;
    logic [HI_W-1:0] addr_hi_q;
    reg_addr_e       ra;

    assign ra       = reg_addr_e'(reg_addr);
    assign tgt_addr = {addr_hi_q, addr_lo_q, 2'b00};

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en        <= 1'b0;
            addr_lo_q <= '0;
            addr_hi_q <= '0;
            cfg_mask  <= '0;
            cfg_pat   <= '0;
        end else if (reg_we) begin
            case (ra)
                RA_ADDR_LO: begin
                    en        <= reg_wdata[0];
                    addr_lo_q <= reg_wdata[31:2];
                end
                RA_ADDR_HI:  addr_hi_q <= reg_wdata[HI_W-1:0];
                RA_DATA_CFG: begin
                    cfg_mask <= reg_wdata[MSG_W-1:HALF_W];
                    cfg_pat  <= reg_wdata[HALF_W-1:0];
                end
                default: ;
            endcase
        end
    end

    // Write strobes toward the status block.
    always_comb begin
        sw_clr  = '0;
        sw_set  = '0;
        msk_set = '0;
        msk_clr = '0;
        if (reg_we) begin
            case (ra)
                RA_CLEAR:    sw_clr  = reg_wdata[STAT_W-1:0];
                RA_SET:      sw_set  = reg_wdata[STAT_W-1:0];
                RA_MASK_SET: msk_set = reg_wdata[STAT_W-1:0];
                RA_MASK_CLR: msk_clr = reg_wdata[STAT_W-1:0];
                default: ;
            endcase
        end
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (ra)
            RA_ADDR_LO:  reg_rdata = {addr_lo_q, 1'b0, en};
            RA_ADDR_HI:  reg_rdata[HI_W-1:0] = addr_hi_q;
            RA_DATA_CFG: reg_rdata = {cfg_mask, cfg_pat};
            RA_STATUS, RA_CLEAR, RA_SET: reg_rdata = status;
            default:     reg_rdata = mask;
        endcase
    end

    // R2: a configuration write is visible on the next cycle.
    assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == RA_DATA_CFG) |=> ({cfg_mask, cfg_pat} == $past(reg_wdata)));

    // R2: the enable follows bit 0 of an address low write.
    assert_enable_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == RA_ADDR_LO) |=> (en == $past(reg_wdata[0])));
endmodule

// File: rtl/msi_status.sv
// Module: msi_status
// Keeps the pending status word and the mask word, merges captures with
// software set/clear strobes (set wins) and drives the interrupt level.
// Assumes: cap_idx is valid whenever cap is high.
module msi_status
    import msi_cap_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap,
    input  logic [VEC_LOG2-1:0] cap_idx,
    input  logic [STAT_W-1:0]   sw_clr,
    input  logic [STAT_W-1:0]   sw_set,
    input  logic [STAT_W-1:0]   msk_set,
    input  logic [STAT_W-1:0]   msk_clr,
    input  logic [STAT_W-1:0]   impl,
    output logic [STAT_W-1:0]   status,
    output logic [STAT_W-1:0]   mask,
    output logic                irq
);
    logic [STAT_W-1:0] cap_vec;
    logic [STAT_W-1:0] set_all;

    // One-hot capture vector merged with software sets.
    always_comb begin
        cap_vec = '0;
        if (cap) cap_vec[cap_idx] = 1'b1;
        set_all = cap_vec | sw_set;
    end

    // Status and mask registers; sets override clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            mask   <= '1;
        end else begin
            status <= (status & ~sw_clr) | set_all;
            mask   <= (mask | msk_set) & ~msk_clr;
        end
    end

    // Interrupt level from pending, unmasked, implemented bits.
    always_comb irq = |(status & ~mask & impl);

    // R4: a captured vector is pending on the next cycle.
    assert_capture_latches_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> status[$past(cap_idx)]);

    // R7: a bit both set and cleared in one cycle ends up set.
    assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sw_set & sw_clr)) |=> ((status & $past(sw_set & sw_clr)) == $past(sw_set & sw_clr)));

    // R9: no interrupt without a pending unmasked bit.
    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|(status & ~mask)));

    // R8: a masked capture still latches.
    assert_masked_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && mask[cap_idx] && msk_clr == '0) |=> (status[$past(cap_idx)] && mask[$past(cap_idx)]));
endmodule

// File: rtl/msi_fwd.sv
// Module: msi_fwd
// Registers inbound writes that were not consumed as interrupt messages and
// presents them downstream one cycle later.
// Assumes: address and data matter only while valid is high.
module msi_fwd
    import msi_cap_pkg::*;
#(
    parameter int ADDR_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [MSG_W-1:0]  in_data,
    input  logic              hit,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [MSG_W-1:0]  out_data
);
    // Pass-through stage for ordinary memory writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid && !hit;
            if (in_valid && !hit) begin
                out_addr <= in_addr;
                out_data <= in_data;
            end
        end
    end

    // R5: an unconsumed write reappears unchanged one cycle later.
    assert_forward_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !hit) |=> (out_valid && out_addr == $past(in_addr) && out_data == $past(in_data)));

    // R5: a consumed write is not forwarded.
    assert_no_forward_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !out_valid);
endmodule

// File: rtl/msi_capture_ctrl.sv
// Module: msi_capture_ctrl (top)
// Recognises interrupt message writes on the inbound path, latches their
// vectors into a status word, forwards all other writes and raises a level
// interrupt. Software programs it through an eight-entry register port.
// Assumes: one inbound write per cycle at most; 32 < ADDR_W <= 64.
module msi_capture_ctrl
    import msi_cap_pkg::*;
#(
    parameter int ADDR_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [MSG_W-1:0]  in_data,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [MSG_W-1:0]  out_data,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [MSG_W-1:0]  reg_wdata,
    output logic [MSG_W-1:0]  reg_rdata,
    output logic              irq
);
    logic                en;
    logic [ADDR_W-1:0]   tgt_addr;
    logic [HALF_W-1:0]   cfg_mask;
    logic [HALF_W-1:0]   cfg_pat;
    logic                hit;
    logic [VEC_LOG2-1:0] cap_idx;
    logic [STAT_W-1:0]   impl;
    logic [STAT_W-1:0]   status;
    logic [STAT_W-1:0]   mask;
    logic [STAT_W-1:0]   sw_clr;
    logic [STAT_W-1:0]   sw_set;
    logic [STAT_W-1:0]   msk_set;
    logic [STAT_W-1:0]   msk_clr;

    msi_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .status    (status),
        .mask      (mask),
        .en        (en),
        .tgt_addr  (tgt_addr),
        .cfg_mask  (cfg_mask),
        .cfg_pat   (cfg_pat),
        .sw_clr    (sw_clr),
        .sw_set    (sw_set),
        .msk_set   (msk_set),
        .msk_clr   (msk_clr),
        .reg_rdata (reg_rdata)
    );

    msi_match #(.ADDR_W(ADDR_W)) u_match (
        .in_valid (in_valid),
        .in_addr  (in_addr),
        .in_data  (in_data),
        .en       (en),
        .tgt_addr (tgt_addr),
        .cfg_mask (cfg_mask),
        .cfg_pat  (cfg_pat),
        .hit      (hit),
        .cap_idx  (cap_idx),
        .impl     (impl)
    );

    msi_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (hit),
        .cap_idx (cap_idx),
        .sw_clr  (sw_clr),
        .sw_set  (sw_set),
        .msk_set (msk_set),
        .msk_clr (msk_clr),
        .impl    (impl),
        .status  (status),
        .mask    (mask),
        .irq     (irq)
    );

    msi_fwd #(.ADDR_W(ADDR_W)) u_fwd (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_addr   (in_addr),
        .in_data   (in_data),
        .hit       (hit),
        .out_valid (out_valid),
        .out_addr  (out_addr),
        .out_data  (out_data)
    );

    // R5: with enable low nothing is consumed.
    assert_disabled_passes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !en) |=> out_valid);
endmodule

// File: tb/msi_capture_ctrl_test.sv
module msi_capture_ctrl_test;
    localparam int AW = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [AW-1:0] in_addr = '0;
    logic [31:0]   in_data = '0;
    logic          out_valid;
    logic [AW-1:0] out_addr;
    logic [31:0]   out_data;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq;

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic          m_en = 1'b0;
    logic [AW-1:0] m_tgt = '0;
    logic [31:0]   m_cfg = '0;
    logic [31:0]   m_stat = '0;
    logic [31:0]   m_mask = '1;

    localparam logic [AW-1:0] TGT = 36'hF_FFFF_FFFC;

    always #10 clk = ~clk;

    msi_capture_ctrl #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data),
        .out_valid(out_valid), .out_addr(out_addr), .out_data(out_data),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int fk(input logic [15:0] m);
        int k = 5;
        for (int i = 4; i >= 0; i--) if (m[i]) k = i;
        return k;
    endfunction

    function automatic int fidx(input logic [31:0] d, input int k);
        return (int'(d[4:0]) & ((1 << k) - 1)) + 32 - (1 << k);
    endfunction

    function automatic logic [31:0] fimpl(input int k);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = (i >= 32 - (1 << k));
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        logic [31:0] r = '0;
        case (a)
            3'd0: r = {m_tgt[31:2], 1'b0, m_en};
            3'd1: r[AW-33:0] = m_tgt[AW-1:32];
            3'd2: r = m_cfg;
            3'd3, 3'd4, 3'd5: r = m_stat;
            default: r = m_mask;
        endcase
        return r;
    endfunction

    // One clock with optional inbound write and register write.
    task automatic cyc(input logic iv, input logic [AW-1:0] ia, input logic [31:0] id,
                       input logic we, input logic [2:0] ra, input logic [31:0] wd,
                       input string req);
        logic hit;
        logic [31:0] clr, set, nmask, ncfg;
        logic nen;
        logic [AW-1:0] ntgt;
        in_valid = iv; in_addr = ia; in_data = id;
        reg_we = we; reg_addr = ra; reg_wdata = wd;
        hit = iv && m_en && (ia == m_tgt) &&
              (((id[15:0] ^ m_cfg[15:0]) & m_cfg[31:16]) == 16'h0);
        clr = '0; set = '0; nmask = m_mask; ncfg = m_cfg; nen = m_en; ntgt = m_tgt;
        if (we) begin
            case (ra)
                3'd0: begin nen = wd[0]; ntgt[31:0] = {wd[31:2], 2'b00}; end
                3'd1: ntgt[AW-1:32] = wd[AW-33:0];
                3'd2: ncfg = wd;
                3'd4: clr = wd;
                3'd5: set = wd;
                3'd6: nmask = nmask | wd;
                3'd7: nmask = nmask & ~wd;
                default: ;
            endcase
        end
        if (hit) set[fidx(id, fk(m_cfg[31:16]))] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        m_stat = (m_stat & ~clr) | set;
        m_mask = nmask; m_cfg = ncfg; m_en = nen; m_tgt = ntgt;
        in_valid = 1'b0; reg_we = 1'b0;
        chk({req, " out_valid"}, 64'(out_valid), 64'(iv && !hit));
        if (iv && !hit) begin
            chk({req, " out_addr"}, 64'(out_addr), 64'(ia));
            chk({req, " out_data"}, 64'(out_data), 64'(id));
        end
        chk({req, " irq"}, 64'(irq), 64'(|(m_stat & ~m_mask & fimpl(fk(m_cfg[31:16])))));
    endtask

    task automatic wr(input logic [2:0] ra, input logic [31:0] wd, input string req);
        cyc(1'b0, '0, '0, 1'b1, ra, wd, req);
    endtask

    task automatic msg(input logic [AW-1:0] a, input logic [31:0] d, input string req);
        cyc(1'b1, a, d, 1'b0, 3'd0, '0, req);
    endtask

    task automatic rd(input logic [2:0] a, input string req);
        reg_addr = a;
        #1;
        chk({req, " read"}, 64'(reg_rdata), 64'(exp_read(a)));
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired (all requirements)");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 8; a++) rd(3'(a), "R1 reset");
        chk("R1 reset irq", 64'(irq), 64'd0);
        chk("R1 reset out_valid", 64'(out_valid), 64'd0);

        // R2 programming
        wr(3'd0, 32'hFFFF_FFFD, "R2 addr lo");
        wr(3'd1, 32'h0000_000F, "R2 addr hi");
        wr(3'd2, 32'hFFE0_6540, "R2 data cfg");
        wr(3'd7, 32'hFFFF_FFFF, "R8 unmask all");
        for (int a = 0; a < 8; a++) rd(3'(a), "R2 readback");

        // R3/R4 32-vector capture
        msg(TGT, 32'h0000_6547, "R4 vec7 32-vector");
        rd(3'd3, "R4 status bit7");
        wr(3'd4, 32'h0000_0080, "R6 clear bit7");
        rd(3'd3, "R6 status cleared");
        msg(TGT, 32'h0000_6447, "R3 data mismatch");
        msg(TGT ^ 36'h100, 32'h0000_6547, "R5 addr mismatch");
        msg(TGT, 32'hABCD_6541, "R3 upper data ignored");
        rd(3'd3, "R3 bit1");
        wr(3'd4, 32'hFFFF_FFFF, "R6 clear all");

        // R4/R9 8-vector mapping
        wr(3'd2, 32'hFFF8_6540, "R4 cfg 8-vector");
        msg(TGT, 32'h0000_6545, "R4 vec5 to bit29");
        rd(3'd3, "R4 bit29");
        wr(3'd5, 32'h0000_0008, "R9 set unimplemented bit3");
        wr(3'd4, 32'h2000_0000, "R9 clear bit29 irq low");
        rd(3'd3, "R9 bit3 only");
        wr(3'd4, 32'h0000_0008, "R6 clear bit3");

        // R5 disabled pass-through
        wr(3'd0, 32'hFFFF_FFFC, "R5 disable");
        msg(TGT, 32'h0000_6541, "R5 disabled match forwarded");
        rd(3'd3, "R5 status unchanged");
        wr(3'd0, 32'hFFFF_FFFD, "R5 re-enable");

        // R7 set beats clear
        cyc(1'b1, TGT, 32'h0000_6542, 1'b1, 3'd4, 32'h0400_0000, "R7 capture vs clear");
        rd(3'd3, "R7 bit26 kept");
        // R10 clear then re-arm
        wr(3'd4, 32'h0400_0000, "R10 clear bit26");
        rd(3'd3, "R10 cleared");
        msg(TGT, 32'h0000_6542, "R10 recapture");
        rd(3'd3, "R10 bit26 again");
        wr(3'd4, 32'hFFFF_FFFF, "R6 clear all");

        // R8 mask behaviour
        wr(3'd6, 32'hFF00_0000, "R8 mask top");
        msg(TGT, 32'h0000_6543, "R8 masked capture");
        rd(3'd3, "R8 masked still latched");
        rd(3'd6, "R8 mask value");
        wr(3'd7, 32'h0800_0000, "R8 unmask bit27 irq");
        // R6 status entry is read-only
        wr(3'd3, 32'hFFFF_FFFF, "R6 status write ignored");
        rd(3'd3, "R6 status unchanged");

        // Random phase
        for (int n = 0; n < 600; n++) begin
            int sel;
            logic [AW-1:0] a;
            logic [31:0] d, w;
            logic [2:0] ra;
            logic we;
            sel = int'($urandom % 10);
            if (sel < 6) begin
                a = ($urandom % 5 == 0) ? {4'($urandom), $urandom} : m_tgt;
                d = $urandom;
                if ($urandom % 4 != 0)
                    d[15:0] = (m_cfg[15:0] & m_cfg[31:16]) | (d[15:0] & ~m_cfg[31:16]);
                we = ($urandom % 3 == 0);
                ra = 3'(4 + $urandom % 4);
                w = ($urandom % 2 == 0) ? (32'h1 << ($urandom % 32)) : $urandom;
                cyc(1'b1, a, d, we, ra, w, "R3 R4 R7 random");
            end else if (sel == 6) begin
                r = $urandom;
                case (r % 3)
                    0: w = 32'hFFE0_6540;
                    1: w = 32'hFFF8_6540;
                    default: w = $urandom;
                endcase
                wr(3'd2, w, "R4 random cfg");
            end else if (sel == 7) begin
                wr(3'd0, {m_tgt[31:2], 1'b0, 1'($urandom % 4 != 0)}, "R5 random enable");
            end else begin
                wr(3'(4 + $urandom % 4), $urandom, "R6 R8 random reg");
            end
            if (n % 8 == 0) begin
                rd(3'd3, "R9 random status");
                rd(3'd6, "R8 random mask");
            end
        end

        summary();
        $finish;
    end
endmodule